// File: doc/BRIEF.md
# Warp Engine Command Token Decoder

This block sits in front of a geometric image-warping engine. It takes a stream of 32-bit command tokens through a valid/ready handshake and turns each accepted token into a write to a 32-entry register file. There are two kinds of token. A configure token names a register and writes it at once. A data token supplies the next item of a job. The number of data tokens in a job depends on the processing mode. A scaling job has three data tokens. A four-corner (tetragon) job has ten.

The block decides which register each data token lands in. After the last token of a job it raises a one-cycle job-start pulse, together with a flag that says which kind of job it was. While that pulse is high, the token input is held off. The register that packs two fractional steps and a pixel offset is split into three output fields. The interpolation type, the scan order and the processing mode are also brought out as fields. Any register can be read back through a combinational read port.

The sequencer has three states. SEQ_IDLE waits for the first data token of a job. SEQ_COLLECT counts the remaining data tokens. SEQ_LAUNCH is the one-cycle pulse state. The transitions are:
- SEQ_IDLE to SEQ_COLLECT on the first data token of a job.
- SEQ_COLLECT to itself on every data token except the last.
- SEQ_COLLECT to SEQ_LAUNCH on the last data token.
- SEQ_LAUNCH back to SEQ_IDLE unconditionally.

Configure tokens never cause a transition.

Top module: `warp_cmd_decoder`

## Requirements
- R1: Token field layout:
  - Bit 31 is the command bit: 1 means configure, 0 means data.
  - Bits 29:25 hold the register ID of a configure token.
  - A configure token carries a 25-bit value in bits 24:0. It is stored zero-extended into a 26-bit register.
  - A data token carries its payload in bits 25:0. Bits 30:26 of a data token are ignored.
  - Bit 30 of a configure token has no effect.
- R2: An accepted configure token writes its register, and the new value is visible on `rd_data` in the next cycle. It never completes a job.
- R3: In scaling mode (bit 0 of register 26 equal to 0), the data tokens of a job write registers 4, 7 and 11, in that order.
- R4: In tetragon mode (bit 0 of register 26 equal to 1), the data tokens of a job write registers 15 to 22, then 7, then 11, in that order.
- R5: The mode is sampled when the first data token of a job is accepted. `job_tetragon` reports the sampled mode while `job_start` is high. A mode write made during the job does not change that job's length.
- R6: A configure token accepted in the middle of a job is applied as a register write. It does not count as one of the job's data tokens.
- R7: `job_start` is high for exactly the one cycle after the last data token of a job is accepted. `tok_ready` is low in that cycle and high in every other cycle out of reset.
- R8: Register 4 is split into three outputs: `frac_x` is bits 9:0, `pix_off` is bits 15:10 and `frac_y` is bits 25:16.
- R9: `interp_sel` is bits 1:0 of register 24, with the codes nearest 0, bilinear 1, bicubic 2 and table 3. `scan_dir` is bit 0 of register 25, where 0 means slide to bottom and 1 means slide to right. `proc_mode` is bit 0 of register 26.
- R10: While reset is held, and in the first cycle after it is released:
  - every register reads 0
  - `tok_ready` is 1
  - `job_start` is 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | A token is offered |
| tok_data | input | 32 | Token word |
| tok_ready | output | 1 | Token accepted at the edge when `tok_valid` is also high |
| rd_idx | input | 5 | Readback register index |
| rd_data | output | 26 | Readback value |
| frac_x | output | 10 | Horizontal fractional step |
| pix_off | output | 6 | Pixel offset field |
| frac_y | output | 10 | Vertical fractional step |
| interp_sel | output | 2 | Interpolation type |
| scan_dir | output | 1 | Scan order |
| proc_mode | output | 1 | Processing mode currently configured |
| job_start | output | 1 | One-cycle pulse when a job's tokens are complete |
| job_tetragon | output | 1 | Mode sampled for the job being started |

## Verification
The bench builds the block with its default parameters: 32 registers of 26 bits, a 25-bit configure value and a ten-slot tetragon job. With these defaults the bench can do three things:
- Sweep the readback index over every register.
- Reach the highest payload bit through a data token.
- Change the mode in the middle of a tetragon job to show that the sampled mode holds.

Back-to-back jobs with `tok_valid` held high exercise the stall in the pulse cycle. A behavioural queue model predicts the ready, pulse, field and readback values in every cycle.

// File: rtl/warp_cmd_pkg.sv
package warp_cmd_pkg;

    localparam int TOK_W     = 32;
    localparam int ID_W      = 5;
    localparam int CFG_W     = 25;
    localparam int REG_W     = 26;
    localparam int NUM_REGS  = 1 << ID_W;
    localparam int CMD_BIT   = TOK_W - 1;
    localparam int ID_LSB    = CFG_W;

    localparam int SCALE_LEN = 3;
    localparam int TETRA_LEN = 10;
    localparam int CNT_W     = $clog2(TETRA_LEN);
    localparam int CORNER_SLOTS = TETRA_LEN - 2;

    localparam logic [ID_W-1:0] IDX_PACKED = 5'd4;
    localparam logic [ID_W-1:0] IDX_SRC    = 5'd7;
    localparam logic [ID_W-1:0] IDX_DST    = 5'd11;
    localparam logic [ID_W-1:0] IDX_P0X    = 5'd15;
    localparam logic [ID_W-1:0] IDX_INTERP = 5'd24;
    localparam logic [ID_W-1:0] IDX_SCAN   = 5'd25;
    localparam logic [ID_W-1:0] IDX_MODE   = 5'd26;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_COLLECT = 2'd1,
        SEQ_LAUNCH  = 2'd2
    } seq_state_t;

    // Register targeted by slot 'pos' of a job of the given kind.
    function automatic logic [ID_W-1:0] job_slot_idx(input logic tetra,
                                                     input logic [CNT_W-1:0] pos);
        logic [ID_W-1:0] idx;
        if (tetra) begin
            if (int'(pos) < CORNER_SLOTS)
                idx = IDX_P0X + ID_W'(pos);
            else if (int'(pos) == CORNER_SLOTS)
                idx = IDX_SRC;
            else
                idx = IDX_DST;
        end else begin
            unique case (pos)
                CNT_W'(0): idx = IDX_PACKED;
                CNT_W'(1): idx = IDX_SRC;
                default:   idx = IDX_DST;
            endcase
        end
        return idx;
    endfunction

endpackage

// File: rtl/warp_tok_fields.sv
module warp_tok_fields
    import warp_cmd_pkg::*;
(
    input  logic [TOK_W-1:0] tok,
    output logic             is_cfg,
    output logic [ID_W-1:0]  cfg_id,
    output logic [REG_W-1:0] cfg_val,
    output logic [REG_W-1:0] data_val
);

    always_comb begin
        is_cfg   = tok[CMD_BIT];
        cfg_id   = tok[ID_LSB +: ID_W];
        cfg_val  = REG_W'(tok[CFG_W-1:0]);
        data_val = tok[REG_W-1:0];
    end

endmodule

// File: rtl/warp_job_seq.sv
module warp_job_seq
    import warp_cmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tok_valid,
    input  logic            is_cfg,
    input  logic            mode_bit,
    output logic            tok_ready,
    output logic            data_we,
    output logic [ID_W-1:0] data_idx,
    output logic            job_start,
    output logic            job_tetra
);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] pos_q, pos_d;
    logic             tetra_q, tetra_d;
    logic             accept_data;
    logic             slot_tetra;
    logic [CNT_W-1:0] last_pos;

    assign accept_data = tok_valid && tok_ready && !is_cfg;
    assign slot_tetra  = (state_q == SEQ_IDLE) ? mode_bit : tetra_q;
    assign last_pos    = tetra_q ? CNT_W'(TETRA_LEN - 1) : CNT_W'(SCALE_LEN - 1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            pos_q   <= '0;
            tetra_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            tetra_q <= tetra_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        tetra_d = tetra_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (accept_data) begin
                    tetra_d = mode_bit;
                    pos_d   = CNT_W'(1);
                    state_d = SEQ_COLLECT;
                end
            end
            SEQ_COLLECT: begin
                if (accept_data) begin
                    if (pos_q == last_pos) begin
                        pos_d   = '0;
                        state_d = SEQ_LAUNCH;
                    end else begin
                        pos_d = pos_q + CNT_W'(1);
                    end
                end
            end
            SEQ_LAUNCH: begin
                state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tok_ready = (state_q != SEQ_LAUNCH);
        job_start = (state_q == SEQ_LAUNCH);
        job_tetra = tetra_q;
        data_we   = accept_data;
        data_idx  = job_slot_idx(slot_tetra, pos_q);
    end

endmodule

// File: rtl/warp_reg_bank.sv
module warp_reg_bank
    import warp_cmd_pkg::*;
#(
    parameter int N     = NUM_REGS,
    parameter int W     = REG_W,
    parameter int IDX_W = ID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data,
    output logic [W-1:0]     packed_q,
    output logic [W-1:0]     interp_q,
    output logic [W-1:0]     scan_q,
    output logic [W-1:0]     mode_q
);

    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(i)))
                regs[i] <= wr_val;
        end
    end

    assign rd_data  = regs[rd_idx];
    assign packed_q = regs[IDX_PACKED];
    assign interp_q = regs[IDX_INTERP];
    assign scan_q   = regs[IDX_SCAN];
    assign mode_q   = regs[IDX_MODE];

endmodule

// File: rtl/warp_cmd_decoder.sv
module warp_cmd_decoder
    import warp_cmd_pkg::*;
#(
    parameter int FRX_W = 10,
    parameter int IPX_W = 6,
    parameter int FRY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [TOK_W-1:0] tok_data,
    output logic             tok_ready,
    input  logic [ID_W-1:0]  rd_idx,
    output logic [REG_W-1:0] rd_data,
    output logic [FRX_W-1:0] frac_x,
    output logic [IPX_W-1:0] pix_off,
    output logic [FRY_W-1:0] frac_y,
    output logic [1:0]       interp_sel,
    output logic             scan_dir,
    output logic             proc_mode,
    output logic             job_start,
    output logic             job_tetragon
);

    localparam int IPX_LSB = FRX_W;
    localparam int FRY_LSB = 16;

    logic             is_cfg;
    logic [ID_W-1:0]  cfg_id;
    logic [REG_W-1:0] cfg_val, data_val;
    logic             data_we;
    logic [ID_W-1:0]  data_idx;
    logic             wr_en;
    logic [ID_W-1:0]  wr_idx;
    logic [REG_W-1:0] wr_val;
    logic [REG_W-1:0] packed_q, interp_q, scan_q, mode_q;

    warp_tok_fields u_fields (
        .tok      (tok_data),
        .is_cfg   (is_cfg),
        .cfg_id   (cfg_id),
        .cfg_val  (cfg_val),
        .data_val (data_val)
    );

    warp_job_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tok_valid),
        .is_cfg    (is_cfg),
        .mode_bit  (mode_q[0]),
        .tok_ready (tok_ready),
        .data_we   (data_we),
        .data_idx  (data_idx),
        .job_start (job_start),
        .job_tetra (job_tetragon)
    );

    assign wr_en  = (tok_valid && tok_ready && is_cfg) || data_we;
    assign wr_idx = is_cfg ? cfg_id  : data_idx;
    assign wr_val = is_cfg ? cfg_val : data_val;

    warp_reg_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .packed_q (packed_q),
        .interp_q (interp_q),
        .scan_q   (scan_q),
        .mode_q   (mode_q)
    );

    assign frac_x     = packed_q[FRX_W-1:0];
    assign pix_off    = packed_q[IPX_LSB +: IPX_W];
    assign frac_y     = packed_q[FRY_LSB +: FRY_W];
    assign interp_sel = interp_q[1:0];
    assign scan_dir   = scan_q[0];
    assign proc_mode  = mode_q[0];

endmodule

// File: rtl/warp_cmd_decoder_chk.sv
module warp_cmd_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tok_valid,
    input logic [31:0] tok_data,
    input logic        tok_ready,
    input logic        job_start,
    input logic [9:0]  frac_x,
    input logic        proc_mode,
    input logic        scan_dir
);

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |=> !job_start);                                            // R7

    AST_READY_LOW_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |-> !tok_ready);                                            // R7

    AST_START_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(job_start) |-> $past(tok_valid && tok_ready && !tok_data[31])); // R2

    AST_PACKED_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ready && tok_data[31] && tok_data[29:25] == 5'd4)
        |=> frac_x == $past(tok_data[9:0]));                                  // R8

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ready && tok_data[31] && tok_data[29:25] == 5'd26)
        |=> proc_mode == $past(tok_data[0]));                                 // R9

    AST_SCAN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ready && tok_data[31] && tok_data[29:25] == 5'd25)
        |=> scan_dir == $past(tok_data[0]));                                  // R9

endmodule

bind warp_cmd_decoder warp_cmd_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_valid (tok_valid),
    .tok_data  (tok_data),
    .tok_ready (tok_ready),
    .job_start (job_start),
    .frac_x    (frac_x),
    .proc_mode (proc_mode),
    .scan_dir  (scan_dir)
);

// File: tb/warp_cmd_decoder_tb.sv
module warp_cmd_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_valid = 1'b0;
    logic [31:0] tok_data = '0;
    logic        tok_ready;
    logic [4:0]  rd_idx = '0;
    logic [25:0] rd_data;
    logic [9:0]  frac_x;
    logic [5:0]  pix_off;
    logic [9:0]  frac_y;
    logic [1:0]  interp_sel;
    logic        scan_dir, proc_mode, job_start, job_tetragon;

    int checks = 0;
    int errors = 0;
    bit sweep_on = 1'b1;
    bit done = 1'b0;

    always #10 clk = ~clk;

    warp_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_data(tok_data),
        .tok_ready(tok_ready), .rd_idx(rd_idx), .rd_data(rd_data),
        .frac_x(frac_x), .pix_off(pix_off), .frac_y(frac_y),
        .interp_sel(interp_sel), .scan_dir(scan_dir), .proc_mode(proc_mode),
        .job_start(job_start), .job_tetragon(job_tetragon)
    );

    // Behavioural reference model
    logic [25:0] m_regs [32];
    int          job_q [$];
    bit          m_launch = 1'b0;
    bit          m_tetra  = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) m_regs[i] = '0;
            job_q.delete();
            m_launch = 1'b0;
            m_tetra  = 1'b0;
        end else begin
            bit nl;
            nl = 1'b0;
            if (tok_valid && !m_launch) begin
                if (tok_data[31]) begin
                    m_regs[tok_data[29:25]] = {1'b0, tok_data[24:0]};
                end else begin
                    int idx;
                    if (job_q.size() == 0) begin
                        m_tetra = m_regs[26][0];
                        if (m_tetra) begin
                            for (int k = 15; k <= 22; k++) job_q.push_back(k);
                            job_q.push_back(7);
                            job_q.push_back(11);
                        end else begin
                            job_q.push_back(4);
                            job_q.push_back(7);
                            job_q.push_back(11);
                        end
                    end
                    idx = job_q.pop_front();
                    m_regs[idx] = tok_data[25:0];
                    if (job_q.size() == 0) nl = 1'b1;
                end
            end
            m_launch = nl;
        end
    end

    always @(posedge clk) begin
        #2;
        if (sweep_on) rd_idx <= rd_idx + 5'd1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tok_ready == !m_launch, "R7 tok_ready", 32'(tok_ready), 32'(!m_launch));
            check(job_start == m_launch, "R7 job_start", 32'(job_start), 32'(m_launch));
            if (m_launch)
                check(job_tetragon == m_tetra, "R5 job_tetragon", 32'(job_tetragon), 32'(m_tetra));
            check(rd_data == m_regs[rd_idx], "R2 rd_data", 32'(rd_data), 32'(m_regs[rd_idx]));
            check({frac_y, pix_off, frac_x} == m_regs[4], "R8 packed fields",
                  32'({frac_y, pix_off, frac_x}), 32'(m_regs[4]));
            check(interp_sel == m_regs[24][1:0] && scan_dir == m_regs[25][0]
                  && proc_mode == m_regs[26][0], "R9 mode fields",
                  32'({interp_sel, scan_dir, proc_mode}),
                  32'({m_regs[24][1:0], m_regs[25][0], m_regs[26][0]}));
        end
    end

    function automatic logic [31:0] cfg(input logic [4:0] id, input logic [24:0] v,
                                        input bit run);
        return {1'b1, run, id, v};
    endfunction

    function automatic logic [31:0] dat(input logic [25:0] v, input logic [4:0] junk);
        return {1'b0, junk, v};
    endfunction

    task automatic send(input logic [31:0] t);
        bit r;
        tok_valid = 1'b1;
        tok_data  = t;
        do begin
            @(negedge clk); r = tok_ready;
            @(posedge clk);
        end while (!r);
        #2;
        tok_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk_reg(input logic [4:0] idx, input logic [25:0] exp, input string tag);
        sweep_on = 1'b0;
        @(negedge clk);
        rd_idx = idx;
        #1;
        check(rd_data == exp, tag, 32'(rd_data), 32'(exp));
        @(posedge clk); #2;
        sweep_on = 1'b1;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd_idx = 5'd26; sweep_on = 1'b0; #1;
        check(tok_ready == 1'b1, "R10 ready in reset", 32'(tok_ready), 32'd1);
        check(job_start == 1'b0, "R10 start in reset", 32'(job_start), 32'd0);
        check(rd_data == '0, "R10 reg clear", 32'(rd_data), 32'd0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        sweep_on = 1'b1;
        idle(1);

        // R1: configure values with the run-type bit set
        send(cfg(5'd24, 25'd2, 1'b1));
        send(cfg(5'd25, 25'd1, 1'b1));
        send(cfg(5'd5, 25'h1ABCDEF, 1'b1));
        chk_reg(5'd5, 26'h1ABCDEF, "R1 cfg zero-extend");
        check(interp_sel == 2'd2, "R9 interp bicubic", 32'(interp_sel), 32'd2);

        // R3/R6: scaling job with a configure in the middle
        send(dat(26'h2C355E7, 5'h1F));
        idle(2);
        send(dat(26'h0123456, 5'h0A));
        send(cfg(5'd24, 25'd1, 1'b0));
        send(dat(26'h3000001, 5'h15));
        idle(2);
        chk_reg(5'd4, 26'h2C355E7, "R3 slot packed");
        check(frac_x == 10'h1E7 && pix_off == 6'h15 && frac_y == 10'h2C3, "R8 split",
              32'({frac_y, pix_off, frac_x}), 32'({10'h2C3, 6'h15, 10'h1E7}));
        chk_reg(5'd7, 26'h0123456, "R3 slot src");
        chk_reg(5'd11, 26'h3000001, "R6 dst after mid-job cfg");
        check(interp_sel == 2'd1, "R6 mid-job cfg applied", 32'(interp_sel), 32'd1);

        // R4/R5: tetragon job, mode cleared mid-job
        send(cfg(5'd26, 25'd1, 1'b0));
        send(dat(26'h07FFFFF, 5'h00));
        for (int i = 1; i < 8; i++) begin
            send(dat(26'h100 + 26'(i), 5'h03));
            if (i == 3) send(cfg(5'd26, 25'd0, 1'b1));
        end
        send(dat(26'h0000AAA, 5'h00));
        send(dat(26'h0000BBB, 5'h00));
        idle(2);
        chk_reg(5'd15, 26'h07FFFFF, "R4 slot P0X");
        chk_reg(5'd22, 26'h0000107, "R4 slot P3Y");
        chk_reg(5'd7, 26'h0000AAA, "R4 slot src");
        chk_reg(5'd11, 26'h0000BBB, "R5 job length kept");
        check(proc_mode == 1'b0, "R9 mode cleared", 32'(proc_mode), 32'd0);

        // R7: back-to-back scaling jobs with valid held
        send(dat(26'h3FFFFFF, 5'h00));
        send(dat(26'h0000001, 5'h00));
        send(dat(26'h0000002, 5'h00));
        send(dat(26'h0000003, 5'h00));
        send(dat(26'h0000004, 5'h00));
        send(dat(26'h0000005, 5'h00));
        idle(2);
        chk_reg(5'd4, 26'h0000003, "R7 second job slot");
        send(cfg(5'd24, 25'd3, 1'b0));
        send(cfg(5'd25, 25'd0, 1'b0));
        idle(1);
        check(interp_sel == 2'd3 && scan_dir == 1'b0, "R9 table/bottom",
              32'({interp_sel, scan_dir}), 32'({2'd3, 1'b0}));
        send(cfg(5'd24, 25'd0, 1'b1));
        idle(40);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule